// File: doc/BRIEF.md
# Task Context Enter/Exit Sequencer

This block carries out the two context-switch operations of a small 8-bit CPU whose tasks each own a base page register D. D is the high byte of the address of both the task's direct page and its return stack; the stack pointer S supplies the low byte. The enter operation saves A, X and Y on the current task's return stack. It then parks the task's page number in X and zeroes A, Y and D, so that handler code runs on page zero. The exit operation first returns D from X and then pulls Y, X and A back from that restored page. The condition flags are not touched by either operation, and the block has no flag port.

The CPU core presents its register values on the `*_in` pins together with a one-cycle `start` strobe and `op_sel`. The block then performs three byte transfers on a valid/ready memory port. It raises `done` for one cycle, and the finished register values appear on the `*_out` pins. A separate `mirq_clr` strobe serves the fast interrupt entry: it takes the register values and forces D to zero without any memory traffic.

Memory port rules: `mem_valid` is high only while a transfer is pending. While `mem_valid` is high and `mem_ready` is low, the block holds `mem_addr`, `mem_wdata` and `mem_write` unchanged. A byte moves in each cycle in which both `mem_valid` and `mem_ready` are high, and `mem_rdata` is sampled in that cycle. The memory may hold off `mem_ready` for any number of cycles.

Top module: `ctx_seq`

## Requirements
- R1: After reset all `*_out` pins are zero, and `done` and `mem_valid` are low.
- R2: With `op_sel`=0 (enter) the block writes (`mem_write`=1) A, then X, then Y, to addresses {D,S}, {D,S-1} and {D,S-2} respectively, using the D and S given at start.
- R3: When an enter finishes, X equals the old D, A, Y and D are zero, and S equals the starting S minus 3.
- R4: With `op_sel`=1 (exit) D takes the value of X before any transfer, and the three reads (`mem_write`=0) go to {X,S+1}, {X,S+2}, {X,S+3}.
- R5: An exit loads Y from the first read, X from the second and A from the third, and finishes with S equal to the starting S plus 3 and D equal to the starting X.
- R6: S arithmetic wraps modulo 256 and never carries into the page byte, in both directions.
- R7: While `mem_valid` is high and `mem_ready` low, the request (address, write data, direction) stays stable. Exactly one byte moves per accepted cycle, and an operation makes exactly three transfers.
- R8: `done` is high for exactly one cycle, the cycle after the last transfer, and the final register values are on the outputs in that cycle.
- R9: A `mirq_clr` strobe while idle sets D to zero, passes A, X, Y and S through unchanged, makes no memory transfer and raises `done` in the next cycle.
- R10: `start`, `op_sel`, `mirq_clr` and the `*_in` pins are ignored while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to run an operation |
| op_sel | input | 1 | 0 = enter, 1 = exit |
| mirq_clr | input | 1 | Fast-interrupt entry strobe: clear D |
| a_in | input | DW | Accumulator value at start |
| x_in | input | DW | X value at start |
| y_in | input | DW | Y value at start |
| d_in | input | DW | Base page value at start |
| s_in | input | DW | Stack pointer value at start |
| a_out | output | DW | Resulting accumulator |
| x_out | output | DW | Resulting X |
| y_out | output | DW | Resulting Y |
| d_out | output | DW | Resulting base page |
| s_out | output | DW | Resulting stack pointer |
| done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Transfer request pending |
| mem_ready | input | 1 | Memory accepts the transfer this cycle |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 2*DW | Page byte and stack byte |
| mem_wdata | output | DW | Byte to write |
| mem_rdata | input | DW | Byte read, valid when ready |

## Verification
Random enter and exit operations use random register values under three memory stall rates: none, about half, and mostly stalled. This separates a correct handshake from one that advances on valid alone or drops data during a stall. Directed cases put S at 00, 01 and FE so that the pointer crosses the page boundary in each direction, which exposes any carry into the page byte. A run in which start, the opposite operation, the interrupt strobe and new register values are all applied mid-operation shows whether late inputs can corrupt a transfer. Interrupt strobes with nonzero D show whether D alone is cleared. Exit reads return a value computed from the address, so a read from the wrong page or in the wrong order lands a wrong value in Y, X or A.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic { OP_ENTER = 1'b0, OP_EXIT = 1'b1 } ctx_op_e;
  typedef enum logic { ST_IDLE = 1'b0, ST_XFER = 1'b1 } ctx_st_e;
  localparam int unsigned CTX_NXFER = 3;
  localparam int unsigned CTX_IW    = $clog2(CTX_NXFER);
endpackage

// File: rtl/ctx_ctrl.sv
module ctx_ctrl
  import ctx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  ctx_op_e           op_sel,
  input  logic              mirq_clr,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic              fire,
  output logic              last,
  output logic              load,
  output logic              mirq_load,
  output ctx_op_e           op_q,
  output logic [CTX_IW-1:0] idx,
  output logic              done
);
  ctx_st_e state;

  assign load      = (state == ST_IDLE) && start;
  assign mirq_load = (state == ST_IDLE) && !start && mirq_clr;
  assign mem_valid = (state == ST_XFER);
  assign fire      = mem_valid && mem_ready;
  assign last      = fire && (idx == CTX_IW'(CTX_NXFER - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q  <= OP_ENTER;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      done <= last || mirq_load;
      if (load) begin
        state <= ST_XFER;
        op_q  <= op_sel;
        idx   <= '0;
      end else if (last) begin
        state <= ST_IDLE;
      end else if (fire) begin
        idx <= idx + CTX_IW'(1);
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !last) |=> (mem_valid && $stable(op_q))); // R10
endmodule

// File: rtl/ctx_regs.sv
module ctx_regs
  import ctx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              mirq_load,
  input  logic              fire,
  input  logic              last,
  input  ctx_op_e           op_sel,
  input  ctx_op_e           op_q,
  input  logic [CTX_IW-1:0] idx,
  input  logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     a_in,
  input  logic [DW-1:0]     x_in,
  input  logic [DW-1:0]     y_in,
  input  logic [DW-1:0]     d_in,
  input  logic [DW-1:0]     s_in,
  output logic [DW-1:0]     a_q,
  output logic [DW-1:0]     x_q,
  output logic [DW-1:0]     y_q,
  output logic [DW-1:0]     d_q,
  output logic [DW-1:0]     s_q
);
  localparam logic [DW-1:0] ONE = DW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; x_q <= '0; y_q <= '0; d_q <= '0; s_q <= '0;
    end else if (load) begin
      a_q <= a_in;
      x_q <= x_in;
      y_q <= y_in;
      if (op_sel == OP_EXIT) begin
        d_q <= x_in;
        s_q <= s_in + ONE;
      end else begin
        d_q <= d_in;
        s_q <= s_in;
      end
    end else if (mirq_load) begin
      a_q <= a_in;
      x_q <= x_in;
      y_q <= y_in;
      s_q <= s_in;
      d_q <= '0;
    end else if (fire) begin
      if (op_q == OP_ENTER) begin
        s_q <= s_q - ONE;
        if (last) begin
          x_q <= d_q;
          a_q <= '0;
          y_q <= '0;
          d_q <= '0;
        end
      end else begin
        case (idx)
          CTX_IW'(0): y_q <= rdata;
          CTX_IW'(1): x_q <= rdata;
          default:    a_q <= rdata;
        endcase
        if (!last) s_q <= s_q + ONE;
      end
    end
  end

  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_q == OP_ENTER) |=> (s_q == $past(s_q) - ONE)); // R2
  AST_ENTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last && op_q == OP_ENTER) |=>
      (a_q == '0 && y_q == '0 && d_q == '0 && x_q == $past(d_q))); // R3
  AST_EXIT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_q == OP_EXIT) |=> $stable(d_q)); // R4
  AST_MIRQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mirq_load |=> (d_q == '0)); // R9
endmodule

// File: rtl/ctx_port.sv
module ctx_port
  import ctx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  ctx_op_e           op_q,
  input  logic [CTX_IW-1:0] idx,
  input  logic [DW-1:0]     a_q,
  input  logic [DW-1:0]     x_q,
  input  logic [DW-1:0]     y_q,
  input  logic [DW-1:0]     d_q,
  input  logic [DW-1:0]     s_q,
  output logic [2*DW-1:0]   mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_write
);
  assign mem_addr  = {d_q, s_q};
  assign mem_write = (op_q == OP_ENTER);

  always_comb begin
    case (idx)
      CTX_IW'(0): mem_wdata = a_q;
      CTX_IW'(1): mem_wdata = x_q;
      default:    mem_wdata = y_q;
    endcase
  end
endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
  import ctx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            op_sel,
  input  logic            mirq_clr,
  input  logic [DW-1:0]   a_in,
  input  logic [DW-1:0]   x_in,
  input  logic [DW-1:0]   y_in,
  input  logic [DW-1:0]   d_in,
  input  logic [DW-1:0]   s_in,
  output logic [DW-1:0]   a_out,
  output logic [DW-1:0]   x_out,
  output logic [DW-1:0]   y_out,
  output logic [DW-1:0]   d_out,
  output logic [DW-1:0]   s_out,
  output logic            done,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_write,
  output logic [2*DW-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata
);
  logic              fire, last, load, mirq_load;
  ctx_op_e           op_q;
  logic [CTX_IW-1:0] idx;

  ctx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(ctx_op_e'(op_sel)),
    .mirq_clr(mirq_clr), .mem_ready(mem_ready), .mem_valid(mem_valid),
    .fire(fire), .last(last), .load(load), .mirq_load(mirq_load),
    .op_q(op_q), .idx(idx), .done(done)
  );

  ctx_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .load(load), .mirq_load(mirq_load),
    .fire(fire), .last(last), .op_sel(ctx_op_e'(op_sel)), .op_q(op_q),
    .idx(idx), .rdata(mem_rdata),
    .a_in(a_in), .x_in(x_in), .y_in(y_in), .d_in(d_in), .s_in(s_in),
    .a_q(a_out), .x_q(x_out), .y_q(y_out), .d_q(d_out), .s_q(s_out)
  );

  ctx_port #(.DW(DW)) u_port (
    .op_q(op_q), .idx(idx), .a_q(a_out), .x_q(x_out), .y_q(y_out),
    .d_q(d_out), .s_q(s_out), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_write(mem_write)
  );

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_write))); // R7
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !done) |=> (!mem_valid || $stable(mem_addr[2*DW-1:DW]))); // R6
endmodule

// File: tb/ctx_seq_test.sv
module ctx_seq_test;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_sel = 1'b0, mirq_clr = 1'b0, mem_ready = 1'b0;
  logic [7:0] a_in = '0, x_in = '0, y_in = '0, d_in = '0, s_in = '0;
  logic [7:0] a_out, x_out, y_out, d_out, s_out, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;
  logic done, mem_valid, mem_write;

  int checks = 0;
  int fails = 0;
  int nlog = 0;
  int stall_pct = 0;
  logic [15:0] log_addr [8];
  logic [7:0]  log_data [8];
  logic        log_we   [8];

  ctx_seq #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .mirq_clr(mirq_clr),
    .a_in(a_in), .x_in(x_in), .y_in(y_in), .d_in(d_in), .s_in(s_in),
    .a_out(a_out), .x_out(x_out), .y_out(y_out), .d_out(d_out), .s_out(s_out),
    .done(done), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] rd_val(input logic [15:0] ad);
    return ad[7:0] ^ {ad[14:8], ad[15]} ^ 8'h5A;
  endfunction

  assign mem_rdata = rd_val(mem_addr);

  always @(negedge clk) mem_ready <= (($urandom % 100) >= stall_pct);

  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (nlog < 8) begin
        log_addr[nlog] = mem_addr;
        log_data[nlog] = mem_write ? mem_wdata : mem_rdata;
        log_we[nlog]   = mem_write;
      end
      nlog = nlog + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // op: 0 = enter, 1 = exit. poke: disturb all inputs mid-operation (R10)
  task automatic run_op(input bit op, input logic [7:0] a, x, y, d, s, input bit poke);
    int n;
    logic [7:0] ea, ex, ey, ed, es;
    @(negedge clk);
    a_in = a; x_in = x; y_in = y; d_in = d; s_in = s;
    op_sel = op; start = 1'b1; nlog = 0;
    @(negedge clk);
    if (poke) begin
      op_sel = ~op; start = 1'b1; mirq_clr = 1'b1;
      a_in = ~a; x_in = ~x; y_in = ~y; d_in = ~d; s_in = ~s;
    end else start = 1'b0;
    @(negedge clk);
    start = 1'b0; mirq_clr = 1'b0;
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk("R8", "done seen", {31'd0, done}, 32'd1);
    chk("R7", "transfer count", nlog, 32'd3);
    for (int i = 0; i < 3; i++) begin
      if (op == 1'b0) begin
        chk("R2", "push addr", {16'd0, log_addr[i]}, {16'd0, d, 8'(s - 8'(i))});
        chk("R2", "push dir", {31'd0, log_we[i]}, 32'd1);
        chk("R2", "push data", {24'd0, log_data[i]},
            {24'd0, (i == 0) ? a : ((i == 1) ? x : y)});
      end else begin
        chk("R4", "pull addr", {16'd0, log_addr[i]}, {16'd0, x, 8'(s + 8'(i + 1))});
        chk("R4", "pull dir", {31'd0, log_we[i]}, 32'd0);
      end
    end
    if (op == 1'b0) begin
      ea = 8'd0; ex = d; ey = 8'd0; ed = 8'd0; es = s - 8'd3;
      chk("R3", "enter a/x/y/d", {a_out, x_out, y_out, d_out}, {ea, ex, ey, ed});
      chk("R6", "enter s", {24'd0, s_out}, {24'd0, es});
    end else begin
      ey = rd_val({x, 8'(s + 8'd1)});
      ex = rd_val({x, 8'(s + 8'd2)});
      ea = rd_val({x, 8'(s + 8'd3)});
      ed = x; es = s + 8'd3;
      chk("R5", "exit a/x/y/d", {a_out, x_out, y_out, d_out}, {ea, ex, ey, ed});
      chk("R6", "exit s", {24'd0, s_out}, {24'd0, es});
    end
    @(negedge clk);
    chk("R8", "done drops", {31'd0, done}, 32'd0);
  endtask

  task automatic run_mirq(input logic [7:0] a, x, y, d, s);
    @(negedge clk);
    a_in = a; x_in = x; y_in = y; d_in = d; s_in = s; mirq_clr = 1'b1; nlog = 0;
    @(negedge clk);
    mirq_clr = 1'b0;
    chk("R9", "mirq done", {31'd0, done}, 32'd1);
    chk("R9", "mirq regs", {a_out, x_out, y_out, d_out}, {a, x, y, 8'd0});
    chk("R9", "mirq s", {24'd0, s_out}, {24'd0, s});
    chk("R9", "mirq no transfer", {31'd0, mem_valid}, 32'd0);
    @(negedge clk);
    chk("R9", "mirq done drops", {31'd0, done}, 32'd0);
    chk("R9", "mirq transfer count", nlog, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    chk("R1", "reset regs", {a_out, x_out, y_out, d_out}, 32'd0);
    chk("R1", "reset s/done/valid", {22'd0, s_out, done, mem_valid}, 32'd0);
    rst_n = 1'b1;
    // directed corners
    run_op(1'b0, 8'h11, 8'h22, 8'h33, 8'h40, 8'h00, 1'b0); // R6 wrap down
    run_op(1'b0, 8'hA5, 8'h5A, 8'hC3, 8'h7F, 8'h01, 1'b0); // R6
    run_op(1'b1, 8'h00, 8'h12, 8'h00, 8'h00, 8'hFE, 1'b0); // R6 wrap up
    run_op(1'b0, 8'h01, 8'h02, 8'h03, 8'h00, 8'hFF, 1'b0);
    run_op(1'b0, 8'h9C, 8'h4D, 8'hE2, 8'h31, 8'h80, 1'b1); // R10
    run_op(1'b1, 8'h9C, 8'h4D, 8'hE2, 8'h31, 8'h80, 1'b1); // R10
    run_mirq(8'h12, 8'h34, 8'h56, 8'h78, 8'h9A);
    run_mirq(8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00);
    // random mix under several stall rates
    for (int p = 0; p < 3; p++) begin
      stall_pct = (p == 0) ? 0 : ((p == 1) ? 50 : 85);
      for (int k = 0; k < 15; k++) begin
        if (($urandom % 6) == 0)
          run_mirq(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
        else
          run_op(1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                 8'($urandom), 8'($urandom), 1'(($urandom % 4) == 0));
      end
    end
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule